// File: doc/BRIEF.md
# Element-Pointer Short Load/Store Unit

This block decodes the compact 16-bit load and store forms that address memory at a small unsigned offset from a dedicated element-pointer register. It takes an instruction halfword together with the current element-pointer value and works out three things: whether the access reads or writes, whether it moves a byte, a halfword or a word, and which general register it uses. It then forms the effective address and issues one request to memory over a valid/ready handshake. For stores it places the source data on the byte lanes and drives the matching byte enables. For loads it waits for the read data, picks out the addressed lane, sign-extends narrow values and presents the result for register writeback.

The displacement field changes meaning with the access size. A byte access uses the seven low instruction bits as they are. A halfword access uses the same seven bits scaled by two. A word access uses six bits scaled by four, and it frees the lowest instruction bit to choose between load and store, so word loads and word stores share a single opcode. When memory accepts at once and answers in the next cycle, a load completes in two clocks and a store in one. A following instruction can be accepted in the same cycle that the previous one completes.

Top module: `ep_short_lsu`

## Requirements
- R1: While reset is held and in the first cycle after it is released, ins_ready is 1, mem_req_valid is 0 and wb_valid is 0.
- R2: Opcode bits ins_word[10:7] decode as follows: 0110 is a byte load, 0111 a byte store, 1000 a halfword load, 1001 a halfword store and 1010 a word access. mem_size is 0 for byte, 1 for halfword and 2 for word. mem_write is 1 for stores. src_reg and wb_reg carry ins_word[15:11].
- R3: For a byte access, mem_addr equals ep_value plus ins_word[6:0] zero-extended, modulo 2^32.
- R4: For a halfword access, mem_addr equals ep_value plus ins_word[6:0] multiplied by 2.
- R5: For a word access, mem_addr equals ep_value plus ins_word[6:1] multiplied by 4. ins_word[0] = 0 selects a load and 1 selects a store.
- R6: mem_be uses little-endian lanes. Byte: bit mem_addr[1:0] alone is set. Halfword: 4'b0011 if mem_addr[1] is 0, otherwise 4'b1100. Word: 4'b1111.
- R7: Store data is src_data[7:0] copied to all four lanes for byte, src_data[15:0] copied to both halves for halfword, and src_data unchanged for word.
- R8: Load writeback takes the addressed byte (lane mem_addr[1:0]) or halfword (upper half when mem_addr[1] is 1) from mem_rdata and sign-extends it to 32 bits. A word load passes mem_rdata through unchanged.
- R9: While mem_req_valid is 1 and mem_req_ready is 0, the request and all its fields stay unchanged in the next cycle.
- R10: A store completes in the cycle its request is accepted. A load raises wb_valid only in a cycle where mem_rsp_valid is 1 after its request was accepted. In every completion cycle ins_ready is 1, so a new instruction can be taken in that same cycle.
- R11: An instruction whose opcode is none of the five listed is consumed with no memory request and no writeback, and ins_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction halfword is present |
| ins_ready | output | 1 | Unit can take an instruction this cycle |
| ins_word | input | 16 | Short-format instruction |
| ep_value | input | ADDR_W | Element-pointer register value |
| src_reg | output | 5 | Register index decoded from ins_word, for the store source read |
| src_data | input | 32 | Value of the register named by src_reg |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Effective address |
| mem_write | output | 1 | 1 for store, 0 for load |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Store data placed on its lanes |
| mem_rsp_valid | input | 1 | Load data returned |
| mem_rdata | input | 32 | Load data word |
| wb_valid | output | 1 | Load result ready for writeback |
| wb_reg | output | 5 | Destination register of the load |
| wb_data | output | 32 | Formatted load result |

## Verification
Completing one access and accepting the next can fall in the same cycle. This happens when a store's request is accepted, or when a load's response arrives, while a new instruction waits on ins_valid. A directed sequence chains a store, a load and a second store in exactly those cycles. In each completion cycle it checks that ins_ready is high and that the writeback is correct. In the following cycle it checks that the new request carries the chained instruction's address and direction. Random traffic with random acceptance and response delays adds further overlaps of stall and completion.

// File: rtl/ep_short_lsu.sv
module ep_short_lsu #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [15:0]       ins_word,
  input  logic [ADDR_W-1:0] ep_value,
  output logic [4:0]        src_reg,
  input  logic [31:0]       src_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_write,
  output logic [1:0]        mem_size,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rdata,
  output logic              wb_valid,
  output logic [4:0]        wb_reg,
  output logic [31:0]       wb_data
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;
  state_t st;

  logic              dec_ok, dec_st;
  logic [1:0]        dec_sz;
  logic [7:0]        dec_off;
  logic [ADDR_W-1:0] dec_addr;
  logic [3:0]        dec_be;
  logic [31:0]       dec_wd;

  logic              r_st;
  logic [1:0]        r_sz;
  logic [4:0]        r_reg;
  logic [ADDR_W-1:0] r_addr;
  logic [3:0]        r_be;
  logic [31:0]       r_wd;

  always_comb begin
    dec_ok  = 1'b1;
    dec_st  = 1'b0;
    dec_sz  = 2'd0;
    dec_off = {1'b0, ins_word[6:0]};
    unique case (ins_word[10:7])
      4'b0110: ;
      4'b0111: dec_st = 1'b1;
      4'b1000: begin dec_sz = 2'd1; dec_off = {ins_word[6:0], 1'b0}; end
      4'b1001: begin dec_sz = 2'd1; dec_off = {ins_word[6:0], 1'b0}; dec_st = 1'b1; end
      4'b1010: begin dec_sz = 2'd2; dec_off = {ins_word[6:1], 2'b00}; dec_st = ins_word[0]; end
      default: dec_ok = 1'b0;
    endcase
  end

  assign dec_addr = ep_value + {{(ADDR_W-8){1'b0}}, dec_off};
  assign src_reg  = ins_word[15:11];

  always_comb begin
    unique case (dec_sz)
      2'd0:    begin dec_be = 4'b0001 << dec_addr[1:0]; dec_wd = {4{src_data[7:0]}}; end
      2'd1:    begin dec_be = dec_addr[1] ? 4'b1100 : 4'b0011; dec_wd = {2{src_data[15:0]}}; end
      default: begin dec_be = 4'b1111; dec_wd = src_data; end
    endcase
  end

  logic done, take;
  assign done      = (st == S_REQ && mem_req_ready && r_st) || (st == S_WAIT && mem_rsp_valid);
  assign ins_ready = (st == S_IDLE) || done;
  assign take      = ins_valid && ins_ready && dec_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)                            st <= S_IDLE;
    else if (ins_ready)                    st <= take ? S_REQ : S_IDLE;
    else if (st == S_REQ && mem_req_ready) st <= S_WAIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_st   <= 1'b0;
      r_sz   <= 2'd0;
      r_reg  <= 5'd0;
      r_addr <= '0;
      r_be   <= 4'd0;
      r_wd   <= 32'd0;
    end else if (take) begin
      r_st   <= dec_st;
      r_sz   <= dec_sz;
      r_reg  <= ins_word[15:11];
      r_addr <= dec_addr;
      r_be   <= dec_be;
      r_wd   <= dec_wd;
    end
  end

  assign mem_req_valid = (st == S_REQ);
  assign mem_addr      = r_addr;
  assign mem_write     = r_st;
  assign mem_size      = r_sz;
  assign mem_be        = r_be;
  assign mem_wdata     = r_wd;

  logic [7:0]  lb;
  logic [15:0] lh;
  always_comb begin
    unique case (r_addr[1:0])
      2'd0: lb = mem_rdata[7:0];
      2'd1: lb = mem_rdata[15:8];
      2'd2: lb = mem_rdata[23:16];
      default: lb = mem_rdata[31:24];
    endcase
    lh = r_addr[1] ? mem_rdata[31:16] : mem_rdata[15:0];
  end

  assign wb_valid = (st == S_WAIT) && mem_rsp_valid;
  assign wb_reg   = r_reg;
  assign wb_data  = (r_sz == 2'd0) ? {{24{lb[7]}}, lb} :
                    (r_sz == 2'd1) ? {{16{lh[15]}}, lh} : mem_rdata;

endmodule

// File: rtl/ep_short_lsu_chk.sv
module ep_short_lsu_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_write,
  input logic [1:0]        mem_size,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic              wb_valid
);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) &&
      $stable(mem_be) && $stable(mem_write) && $stable(mem_wdata) && $stable(mem_size));

  p_be_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> $countones(mem_be) ==
      ((mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4));

  p_half_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_size == 2'd1 |-> (mem_be == 4'b0011 || mem_be == 4'b1100));

  p_size_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_size != 2'd3);

  p_store_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && mem_write |=> !wb_valid);

  p_load_waits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && !mem_write |=> !mem_req_valid);

  p_wb_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ins_ready && !mem_req_valid);

endmodule

bind ep_short_lsu ep_short_lsu_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/ep_short_lsu_tb_top.sv
module ep_short_lsu_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, ins_valid, ins_ready, mem_req_valid, mem_req_ready;
  logic [15:0] ins_word;
  logic [31:0] ep_value, src_data, mem_addr, mem_wdata, mem_rdata, wb_data;
  logic [4:0]  src_reg, wb_reg;
  logic        mem_write, mem_rsp_valid, wb_valid;
  logic [1:0]  mem_size;
  logic [3:0]  mem_be;

  ep_short_lsu dut_i (.*);

  int total = 0, fails = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic ex_legal(logic [15:0] w);
    return w[10:7] inside {4'b0110, 4'b0111, 4'b1000, 4'b1001, 4'b1010};
  endfunction
  function automatic logic ex_store(logic [15:0] w);
    return w[10:7] == 4'b0111 || w[10:7] == 4'b1001 || (w[10:7] == 4'b1010 && w[0]);
  endfunction
  function automatic logic [1:0] ex_size(logic [15:0] w);
    if (w[10:7] == 4'b0110 || w[10:7] == 4'b0111) return 2'd0;
    if (w[10:7] == 4'b1000 || w[10:7] == 4'b1001) return 2'd1;
    return 2'd2;
  endfunction
  function automatic logic [31:0] ex_addr(logic [15:0] w, logic [31:0] ep);
    case (ex_size(w))
      2'd0:    return ep + 32'(w[6:0]);
      2'd1:    return ep + 32'(w[6:0]) * 2;
      default: return ep + 32'(w[6:1]) * 4;
    endcase
  endfunction
  function automatic logic [3:0] ex_be(logic [1:0] sz, logic [31:0] a);
    if (sz == 2'd0) return 4'(1 << a[1:0]);
    if (sz == 2'd1) return a[1] ? 4'hC : 4'h3;
    return 4'hF;
  endfunction
  function automatic logic [31:0] ex_wd(logic [1:0] sz, logic [31:0] s);
    if (sz == 2'd0) return {s[7:0], s[7:0], s[7:0], s[7:0]};
    if (sz == 2'd1) return {s[15:0], s[15:0]};
    return s;
  endfunction
  function automatic logic [31:0] ex_load(logic [1:0] sz, logic [31:0] a, logic [31:0] rd);
    logic [7:0] b;
    logic [15:0] h;
    b = rd[8*a[1:0] +: 8];
    h = a[1] ? rd[31:16] : rd[15:0];
    if (sz == 2'd0) return {{24{b[7]}}, b};
    if (sz == 2'd1) return {{16{h[15]}}, h};
    return rd;
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic check_req(logic [15:0] w, logic [31:0] ep, logic [31:0] s);
    logic [31:0] a;
    a = ex_addr(w, ep);
    chk("R9 req valid", 32'(mem_req_valid), 1);
    chk(ex_size(w) == 0 ? "R3 addr" : ex_size(w) == 1 ? "R4 addr" : "R5 addr", mem_addr, a);
    chk("R2/R5 write", 32'(mem_write), 32'(ex_store(w)));
    chk("R2 size", 32'(mem_size), 32'(ex_size(w)));
    chk("R6 be", 32'(mem_be), 32'(ex_be(ex_size(w), a)));
    if (ex_store(w)) chk("R7 wdata", mem_wdata, ex_wd(ex_size(w), s));
  endtask

  task automatic run_op(logic [15:0] w, logic [31:0] ep, logic [31:0] s,
                        logic [31:0] rd, int rdly, int sdly);
    ins_valid = 1; ins_word = w; ep_value = ep; src_data = s;
    #1 chk("R10 ready idle", 32'(ins_ready), 1);
    chk("R2 src_reg", 32'(src_reg), 32'(w[15:11]));
    @(posedge clk); @(negedge clk);
    ins_valid = 0;
    if (!ex_legal(w)) begin
      #1 chk("R11 no req", 32'(mem_req_valid), 0);
      chk("R11 ready", 32'(ins_ready), 1);
      return;
    end
    for (int i = 0; i < rdly; i++) begin
      #1 check_req(w, ep, s);
      chk("R10 no ready in stall", 32'(ins_ready), 0);
      @(posedge clk); @(negedge clk);
    end
    mem_req_ready = 1;
    #1 check_req(w, ep, s);
    chk("R10 ready at store accept", 32'(ins_ready), 32'(ex_store(w)));
    @(posedge clk); @(negedge clk);
    mem_req_ready = 0;
    if (ex_store(w)) return;
    for (int i = 0; i < sdly; i++) begin
      #1 chk("R10 no early wb", 32'(wb_valid), 0);
      @(posedge clk); @(negedge clk);
    end
    mem_rsp_valid = 1; mem_rdata = rd;
    #1 chk("R10 wb valid", 32'(wb_valid), 1);
    chk("R2 wb_reg", 32'(wb_reg), 32'(w[15:11]));
    chk("R8 wb_data", wb_data, ex_load(ex_size(w), ex_addr(w, ep), rd));
    @(posedge clk); @(negedge clk);
    mem_rsp_valid = 0;
  endtask

  function automatic logic [15:0] gen_ins();
    logic [15:0] w;
    w = 16'($urandom);
    case ($urandom % 6)
      0: w[10:7] = 4'b0110;
      1: w[10:7] = 4'b0111;
      2: w[10:7] = 4'b1000;
      3: w[10:7] = 4'b1001;
      4: w[10:7] = 4'b1010;
      default: ;
    endcase
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] w1, w2, w3;
    void'($urandom(32'h5EED_0042));
    rst_n = 0; ins_valid = 0; ins_word = 0; ep_value = 0; src_data = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    #1 chk("R1 ready in reset", 32'(ins_ready), 1);
    chk("R1 no req in reset", 32'(mem_req_valid), 0);
    rst_n = 1;
    @(negedge clk);
    #1 chk("R1 ready", 32'(ins_ready), 1);
    chk("R1 no req", 32'(mem_req_valid), 0);
    chk("R1 no wb", 32'(wb_valid), 0);
    @(negedge clk);

    // R3 wrap past top of address space
    run_op({5'd3, 4'b0110, 7'h7F}, 32'hFFFF_FFF0, 0, 32'h80FF_7F01, 0, 0);
    // R4 halfword upper lane, negative
    run_op({5'd9, 4'b1000, 7'h01}, 32'h0000_1000, 0, 32'h8001_1234, 1, 2);
    // R5 word load, max displacement
    run_op({5'd31, 4'b1010, 7'h7E}, 32'h0000_2000, 0, 32'hDEAD_BEEF, 0, 0);
    // R5 word store via bit 0
    run_op({5'd1, 4'b1010, 7'h03}, 32'h0000_0100, 32'hCAFE_F00D, 0, 2, 0);
    // R7 byte store lane 3, R8 byte load lane 3 sign
    run_op({5'd4, 4'b0111, 7'h03}, 32'h0, 32'h1234_56A5, 0, 0, 0);
    run_op({5'd4, 4'b0110, 7'h03}, 32'h0, 0, 32'h8000_0000, 0, 1);
    // R11 ignored opcode
    run_op({5'd7, 4'b0000, 7'h11}, 32'h40, 0, 0, 0, 0);
    run_op({5'd7, 4'b1111, 7'h11}, 32'h40, 0, 0, 0, 0);

    // R10 completion and acceptance in the same cycle
    w1 = {5'd2, 4'b1001, 7'h05};
    w2 = {5'd6, 4'b0110, 7'h22};
    w3 = {5'd8, 4'b0111, 7'h01};
    ins_valid = 1; ins_word = w1; ep_value = 32'h300; src_data = 32'hAAAA_5555;
    @(posedge clk); @(negedge clk);
    mem_req_ready = 1; ins_word = w2; ep_value = 32'h500; src_data = 0;
    #1 chk("R10 ready on store accept", 32'(ins_ready), 1);
    check_req(w1, 32'h300, 32'hAAAA_5555);
    @(posedge clk); @(negedge clk);
    ins_valid = 0;
    #1 check_req(w2, 32'h500, 0);
    @(posedge clk); @(negedge clk);
    mem_req_ready = 0; mem_rsp_valid = 1; mem_rdata = 32'h0000_7F00;
    ins_valid = 1; ins_word = w3; ep_value = 32'h600; src_data = 32'h0000_00C3;
    #1 chk("R10 wb in chain", 32'(wb_valid), 1);
    chk("R8 chain data", wb_data, ex_load(2'd0, ex_addr(w2, 32'h500), 32'h0000_7F00));
    chk("R10 ready on rsp", 32'(ins_ready), 1);
    @(posedge clk); @(negedge clk);
    mem_rsp_valid = 0; ins_valid = 0;
    #1 check_req(w3, 32'h600, 32'h0000_00C3);
    mem_req_ready = 1;
    @(posedge clk); @(negedge clk);
    mem_req_ready = 0;
    #1 chk("R10 idle after chain", 32'(mem_req_valid), 0);

    for (int n = 0; n < 300; n++)
      run_op(gen_ins(), $urandom, $urandom, $urandom, $urandom % 3, $urandom % 3);

    summary();
    $finish;
  end
endmodule